// File: doc/BRIEF.md
# Emergency Fault Shutdown Controller

This block guards a three-phase motor drive against an external emergency signal. The same pin can also act as a wake-up line. The asynchronous input first passes through a synchronizer. When an active edge then appears and the trip function is enabled, all six phase outputs (high and low side for each of the three phases) are released to high impedance in that same cycle. On the next clock a sticky emergency flag is set, and this flag drives a non-maskable interrupt request toward the processor.

A second, processor-side pending bit records each new request. It is set only when the sticky flag rises from clear, and it is cleared by the processor's acknowledge pulse. The sticky flag itself clears only on a software write. Software should issue that write after the emergency line has gone inactive again. Once the flag is clear, an explicit re-arm write returns the phase outputs to normal drive from the PWM source. Two enables pick emergency-only, wake-up-only, or combined operation. Phase outputs are shown as an enable vector (1 = driving, 0 = high impedance) plus the gated drive value.

Top module: `fault_stop_ctrl`

## Requirements
- R1: After reset, flag_o, nmi_req, cpu_pend and wake_o are 0, phase_oe is all ones and phase_drv equals pwm_in.
- R2: With trip_en=1, an active edge (rising, with default ACTIVE_RISE=1) on line_in is seen two clock edges after the input changes. In that cycle phase_oe becomes all zeros and phase_drv becomes all zeros.
- R3: One clock after the trip event, flag_o is 1, and nmi_req follows flag_o at all times.
- R4: flag_o is sticky. It stays 1 after line_in returns low, however many cycles pass, and only a one-cycle pulse on sw_clr clears it.
- R5: If sw_clr is asserted in the same cycle as a new trip event, flag_o stays 1.
- R6: cpu_pend is set one clock after a trip event that finds flag_o clear, and cpu_ack clears it. A trip event that arrives while flag_o is already 1 does not set cpu_pend, so that event is lost.
- R7: A level that stays high does not retrigger. If flag_o is cleared while line_in is still high, no new request follows until line_in goes low and a fresh active edge arrives.
- R8: With trip_en=0 an edge leaves flag_o, cpu_pend and phase_oe unchanged. wake_o pulses for exactly the event cycle whenever wake_en=1, whatever the value of trip_en.
- R9: The phase outputs stay in high impedance until sw_rearm is pulsed while flag_o is 0. A re-arm while flag_o is 1 is ignored. When re-armed, phase_oe is all ones and phase_drv equals pwm_in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | 1 | Asynchronous emergency / wake-up input |
| trip_en | input | 1 | Enables the shutdown, flag and interrupt function |
| wake_en | input | 1 | Enables the wake-up pulse |
| pwm_in | input | NUM_PHASES | Phase drive values from the PWM source |
| sw_clr | input | 1 | Software write pulse that clears the sticky flag |
| sw_rearm | input | 1 | Software write pulse that re-enables the phase outputs |
| cpu_ack | input | 1 | Processor acknowledge of the non-maskable interrupt |
| phase_oe | output | NUM_PHASES | Per-phase output enable, 0 means high impedance |
| phase_drv | output | NUM_PHASES | Per-phase drive value, forced to 0 while released |
| flag_o | output | 1 | Sticky emergency flag |
| nmi_req | output | 1 | Non-maskable interrupt request |
| cpu_pend | output | 1 | Processor-side pending bit |
| wake_o | output | 1 | One-cycle wake-up pulse |

## Verification
Four enable combinations are applied to the same rising edge. They separate the wake path from the trip path: a release without a flag, or a wake pulse leaking through the wrong enable, would each show up in one of them. Further edge patterns check the corner cases. A second edge arriving while the flag is still set must leave the pending bit clear. A clear that coincides with a new edge must leave the flag set. A clear issued while the line is still held high must produce no new request until the line has dropped and risen again. Re-arm attempts made before and after the clear show whether the release is tied to the flag state.

// File: rtl/fs_pkg.sv
package fs_pkg;

  function automatic logic edge_seen(input logic cur, input logic prev, input logic rise);
    return rise ? (cur & ~prev) : (~cur & prev);
  endfunction

  function automatic logic flag_next(input logic flag, input logic set, input logic clr);
    return set | (flag & ~clr);
  endfunction

  function automatic logic release_next(input logic rel, input logic set,
                                        input logic rearm, input logic flag);
    return set | (rel & ~(rearm & ~flag));
  endfunction

  function automatic logic pend_next(input logic pend, input logic set, input logic ack);
    return set | (pend & ~ack);
  endfunction

endpackage

// File: rtl/fs_line_sync.sv
module fs_line_sync #(
  parameter int STAGES      = 2,
  parameter bit ACTIVE_RISE = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic edge_o
);
  import fs_pkg::*;

  localparam logic IDLE = ~ACTIVE_RISE;

  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= IDLE;
        else        chain_q <= line_in;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{IDLE}};
        else        chain_q <= {chain_q[STAGES-2:0], line_in};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= IDLE;
    else        prev_q <= chain_q[STAGES-1];
  end

  assign edge_o = edge_seen(chain_q[STAGES-1], prev_q, ACTIVE_RISE);

endmodule

// File: rtl/fs_trip_latch.sv
module fs_trip_latch #(
  parameter int NUM_PHASES = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  trip_ev,
  input  logic                  sw_clr,
  input  logic                  sw_rearm,
  input  logic [NUM_PHASES-1:0] pwm_in,
  output logic                  flag_o,
  output logic                  released_o,
  output logic [NUM_PHASES-1:0] phase_oe,
  output logic [NUM_PHASES-1:0] phase_drv
);
  import fs_pkg::*;

  logic flag_q;
  logic rel_q;
  logic hiz;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      rel_q  <= 1'b0;
    end else begin
      flag_q <= flag_next(flag_q, trip_ev, sw_clr);
      rel_q  <= release_next(rel_q, trip_ev, sw_rearm, flag_q);
    end
  end

  // Release takes effect in the event cycle itself, without waiting a clock.
  assign hiz = rel_q | trip_ev;

  generate
    for (genvar i = 0; i < NUM_PHASES; i++) begin : g_phase
      assign phase_oe[i]  = ~hiz;
      assign phase_drv[i] = pwm_in[i] & ~hiz;
    end
  endgenerate

  assign flag_o     = flag_q;
  assign released_o = rel_q;

endmodule

// File: rtl/fs_nmi_pend.sv
module fs_nmi_pend (
  input  logic clk,
  input  logic rst_n,
  input  logic trip_ev,
  input  logic flag_q,
  input  logic cpu_ack,
  output logic cpu_pend
);
  import fs_pkg::*;

  logic pend_q;
  logic req_rise;

  // The processor only notices a request that rises from a clear flag.
  assign req_rise = trip_ev & ~flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_next(pend_q, req_rise, cpu_ack);
  end

  assign cpu_pend = pend_q;

endmodule

// File: rtl/fault_stop_ctrl.sv
module fault_stop_ctrl #(
  parameter int NUM_PHASES  = 6,
  parameter int SYNC_STAGES = 2,
  parameter bit ACTIVE_RISE = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  line_in,
  input  logic                  trip_en,
  input  logic                  wake_en,
  input  logic [NUM_PHASES-1:0] pwm_in,
  input  logic                  sw_clr,
  input  logic                  sw_rearm,
  input  logic                  cpu_ack,
  output logic [NUM_PHASES-1:0] phase_oe,
  output logic [NUM_PHASES-1:0] phase_drv,
  output logic                  flag_o,
  output logic                  nmi_req,
  output logic                  cpu_pend,
  output logic                  wake_o
);

  logic line_edge;
  logic trip_ev;
  logic released;

  fs_line_sync #(
    .STAGES      (SYNC_STAGES),
    .ACTIVE_RISE (ACTIVE_RISE)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .line_in (line_in),
    .edge_o  (line_edge)
  );

  assign trip_ev = line_edge & trip_en;
  assign wake_o  = line_edge & wake_en;

  fs_trip_latch #(
    .NUM_PHASES (NUM_PHASES)
  ) u_latch (
    .clk        (clk),
    .rst_n      (rst_n),
    .trip_ev    (trip_ev),
    .sw_clr     (sw_clr),
    .sw_rearm   (sw_rearm),
    .pwm_in     (pwm_in),
    .flag_o     (flag_o),
    .released_o (released),
    .phase_oe   (phase_oe),
    .phase_drv  (phase_drv)
  );

  fs_nmi_pend u_pend (
    .clk      (clk),
    .rst_n    (rst_n),
    .trip_ev  (trip_ev),
    .flag_q   (flag_o),
    .cpu_ack  (cpu_ack),
    .cpu_pend (cpu_pend)
  );

  assign nmi_req = flag_o;

endmodule

// File: rtl/fs_ctrl_checker.sv
module fs_ctrl_checker #(
  parameter int NUM_PHASES = 6
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  trip_ev,
  input logic                  released,
  input logic                  sw_clr,
  input logic                  sw_rearm,
  input logic                  cpu_ack,
  input logic [NUM_PHASES-1:0] phase_oe,
  input logic                  flag_o,
  input logic                  nmi_req,
  input logic                  cpu_pend,
  input logic                  wake_o
);

  p_hiz_on_trip_r2: assert property (@(posedge clk) disable iff (!rst_n)
    trip_ev |-> (phase_oe == '0));

  p_flag_after_trip_r3: assert property (@(posedge clk) disable iff (!rst_n)
    trip_ev |=> flag_o);

  p_req_follows_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_req == flag_o);

  p_flag_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && !sw_clr) |=> flag_o);

  p_flag_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && sw_clr && !trip_ev) |=> !flag_o);

  p_clear_loses_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (trip_ev && sw_clr) |=> flag_o);

  p_pend_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_pend && !cpu_ack) |=> cpu_pend);

  p_pend_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_pend && cpu_ack && !(trip_ev && !flag_o)) |=> !cpu_pend);

  p_no_pend_when_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_pend && flag_o && trip_ev) |=> !cpu_pend);

  p_wake_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |=> !wake_o);

  p_flag_keeps_hiz_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flag_o |-> (phase_oe == '0));

  p_release_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (released && !sw_rearm) |=> (phase_oe == '0));

endmodule

bind fault_stop_ctrl fs_ctrl_checker #(.NUM_PHASES(NUM_PHASES)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .trip_ev  (trip_ev),
  .released (released),
  .sw_clr   (sw_clr),
  .sw_rearm (sw_rearm),
  .cpu_ack  (cpu_ack),
  .phase_oe (phase_oe),
  .flag_o   (flag_o),
  .nmi_req  (nmi_req),
  .cpu_pend (cpu_pend),
  .wake_o   (wake_o)
);

// File: tb/fault_stop_ctrl_test.sv
`timescale 1ns/1ps
module fault_stop_ctrl_test;

  localparam int NP = 6;
  localparam logic [NP-1:0] ALL = '1;
  localparam logic [NP-1:0] PWM = 6'b101101;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_in = 1'b0, trip_en = 1'b0, wake_en = 1'b0;
  logic [NP-1:0] pwm_in = PWM;
  logic sw_clr = 1'b0, sw_rearm = 1'b0, cpu_ack = 1'b0;
  logic [NP-1:0] phase_oe, phase_drv;
  logic flag_o, nmi_req, cpu_pend, wake_o;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  fault_stop_ctrl #(.NUM_PHASES(NP)) uut (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .trip_en(trip_en),
    .wake_en(wake_en), .pwm_in(pwm_in), .sw_clr(sw_clr), .sw_rearm(sw_rearm),
    .cpu_ack(cpu_ack), .phase_oe(phase_oe), .phase_drv(phase_drv),
    .flag_o(flag_o), .nmi_req(nmi_req), .cpu_pend(cpu_pend), .wake_o(wake_o)
  );

  // Vector fields: {trip_en, wake_en, exp_hiz, exp_flag, exp_wake}
  localparam logic [4:0] VEC [4] = '{
    5'b00000,
    5'b01001,
    5'b10110,
    5'b11111
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic pulse_clr();
    sw_clr = 1'b1; @(negedge clk); sw_clr = 1'b0;
  endtask

  task automatic pulse_ack();
    cpu_ack = 1'b1; @(negedge clk); cpu_ack = 1'b0;
  endtask

  task automatic pulse_rearm();
    sw_rearm = 1'b1; @(negedge clk); sw_rearm = 1'b0;
  endtask

  // Raises line_in and returns at the negedge inside the event cycle.
  task automatic raise_to_event();
    line_in = 1'b1;
    wait_n(2);
  endtask

  task automatic restore();
    line_in = 1'b0;
    wait_n(3);
    pulse_ack();
    pulse_clr();
    pulse_rearm();
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);

    // R1: reset state
    check(flag_o == 0 && nmi_req == 0 && cpu_pend == 0 && wake_o == 0, "R1 flags",
          {flag_o, nmi_req, cpu_pend, wake_o}, 0);
    check(phase_oe == ALL && phase_drv == PWM, "R1 outputs", {phase_oe, phase_drv}, {ALL, PWM});

    // Table walk over enable combinations (R2, R3, R6, R8)
    for (int i = 0; i < 4; i++) begin
      logic [4:0] v;
      v = VEC[i];
      trip_en = v[4]; wake_en = v[3];
      wait_n(2);
      raise_to_event();
      check(wake_o == v[0], "R8 wake pulse", wake_o, v[0]);
      check(phase_oe == (v[2] ? '0 : ALL), "R2 release in event cycle", phase_oe, v[2] ? 0 : ALL);
      check(phase_drv == (v[2] ? '0 : PWM), "R2 drive forced", phase_drv, v[2] ? 0 : PWM);
      wait_n(1);
      check(flag_o == v[1] && nmi_req == v[1], "R3 flag and request", {flag_o, nmi_req}, {v[1], v[1]});
      check(cpu_pend == v[1], "R6 pend set", cpu_pend, v[1]);
      check(wake_o == 0, "R8 wake one cycle", wake_o, 0);
      restore();
      check(flag_o == 0 && cpu_pend == 0 && phase_oe == ALL, "R9 restored",
            {flag_o, cpu_pend, phase_oe}, {2'b00, ALL});
    end

    // R4 sticky, R9 re-arm blocked, R6 ack and lost event
    trip_en = 1'b1; wake_en = 1'b0;
    raise_to_event();
    wait_n(1);
    line_in = 1'b0;
    wait_n(20);
    check(flag_o == 1, "R4 flag sticky after line drop", flag_o, 1);
    pulse_rearm();
    wait_n(1);
    check(phase_oe == '0, "R9 rearm ignored while flag set", phase_oe, 0);
    pulse_ack();
    check(cpu_pend == 0, "R6 ack clears pend", cpu_pend, 0);
    raise_to_event();
    wait_n(2);
    check(cpu_pend == 0 && flag_o == 1, "R6 second edge lost while flag set",
          {cpu_pend, flag_o}, 2'b01);
    line_in = 1'b0;
    wait_n(3);

    // R5: clear in the same cycle as a new event
    raise_to_event();
    sw_clr = 1'b1;
    wait_n(1);
    sw_clr = 1'b0;
    check(flag_o == 1, "R5 event beats clear", flag_o, 1);

    // R7: clear while line held high
    wait_n(2);
    pulse_clr();
    wait_n(5);
    check(flag_o == 0 && cpu_pend == 0, "R7 no retrigger on held level",
          {flag_o, cpu_pend}, 0);
    line_in = 1'b0;
    wait_n(3);
    raise_to_event();
    wait_n(1);
    check(flag_o == 1 && cpu_pend == 1, "R7 fresh edge after drop", {flag_o, cpu_pend}, 2'b11);

    // R4 clear, R9 re-arm after clear
    line_in = 1'b0;
    wait_n(3);
    pulse_clr();
    check(flag_o == 0 && phase_oe == '0, "R4 clear keeps release", {flag_o, phase_oe}, 0);
    pulse_rearm();
    check(phase_oe == ALL && phase_drv == PWM, "R9 rearm restores drive",
          {phase_oe, phase_drv}, {ALL, PWM});

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule